// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Datapath

This block is the arithmetic core of a signal-processing unit. Each cycle it takes two 16-bit operands and one opcode, and it updates one of two 40-bit accumulators.

The operands are extended to 17 bits and multiplied in a shared 17x17 multiplier. The product is either shifted for fractional use or kept as an integer. It is then sign-extended to 40 bits and passed through a 41-bit adder/subtracter together with the chosen accumulator, the other accumulator, or zero. An optional clamp is applied before the result is written back.

The opcode family covers the following operations:
- product load and negated product load;
- accumulate and subtract-accumulate;
- squares;
- squared differences, with and without accumulation;
- accumulator-to-accumulator add, subtract and negate;
- clear.

Per-accumulator sticky flags record range overflow and clamping. A combinational store port rounds either accumulator to a 16-bit word and can clamp that word.

Top module: `dmac_engine`

## Requirements
- R1: After reset both accumulators are zero, all four sticky flags are low, and store_data is 16'h0000.
- R2: An operation takes effect at the clock edge where op_valid is high. The opcode values are:

  | Code | Name | Effect on target T |
  |------|------|--------------------|
  | 0 | NOP | none |
  | 1 | CLR | T = 0 |
  | 2 | MPY | T = x*y |
  | 3 | MPYN | T = -(x*y) |
  | 4 | MAC | T = T + x*y |
  | 5 | MSC | T = T - x*y |
  | 6 | SQR | T = x*x |
  | 7 | SQRAC | T = T + x*x |
  | 8 | ED | T = (x-y)^2 |
  | 9 | EDAC | T = T + (x-y)^2 |
  | 10 | ADD | T = A + B |
  | 11 | SUB | T = T - other |
  | 12 | NEG | T = -T |

  Codes 13 to 15 act as NOP. The target is A when acc_sel is 0 and B when acc_sel is 1. The other accumulator is never changed, and nothing changes while op_valid is low.
- R3: CLR loads the target accumulator with zero.
- R4: In integer mode with signed operands, MPY, MPYN, MAC and MSC give the exact two's-complement product results, sign-extended to 40 bits.
- R5: When frac_mode is 1 the product is shifted left by one bit before extension. For example, 16'h4000 times 16'h4000 gives 40'h0020000000.
- R6: When opnd_unsigned is 1 both multiply operands are zero-extended. For example, 16'hFFFF times 16'h0002 gives 40'h000001FFFE.
- R7: SQR and SQRAC use x for both factors. ED and EDAC square the signed 17-bit difference x-y, whatever the value of opnd_unsigned.
- R8: ADD writes A+B into the target. SUB writes the target minus the other accumulator. NEG writes the negated target.
- R9: When saturation is enabled for the target and sat_mode is 0, a result above 40'h007FFFFFFF is written as 40'h007FFFFFFF. A result below 40'hFF80000000 is written as 40'hFF80000000.
- R10: When sat_mode is 1, results are clamped to 40'h7FFFFFFFFF and 40'h8000000000. When saturation is disabled for the target, results wrap modulo 2^40.
- R11: The ovf flag of the target is set when a result falls outside the 32-bit signed range before any clamp. Its sat flag is set when the clamp is applied. Both flags hold until flag_clr, which clears all four flags and takes priority over setting.
- R12: store_data is bits [31:16] of the accumulator selected by store_sel after 40'h8000 has been added to it.
- R13: When rnd_conv is 1 and bits [15:0] of the accumulator equal 16'h8000, the 40'h8000 is added only if bit 16 is 1, so the rounded result is even.
- R14: When store_sat_en is 1 and bits [39:31] of the rounded value disagree, store_data is 16'h7FFF for a positive value and 16'h8000 for a negative one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Execute op_code this cycle |
| op_code | input | 4 | Operation select (see R2) |
| acc_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| frac_mode | input | 1 | 1 = fractional product shift |
| opnd_unsigned | input | 1 | 1 = zero-extend multiply operands |
| rnd_conv | input | 1 | 1 = convergent store rounding |
| sat_en_a | input | 1 | Clamp writes to A |
| sat_en_b | input | 1 | Clamp writes to B |
| sat_mode | input | 1 | 0 = 32-bit clamp point, 1 = 40-bit |
| store_sat_en | input | 1 | Clamp the store word |
| store_sel | input | 1 | Store source: 0 = A, 1 = B |
| flag_clr | input | 1 | Clear all sticky flags |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| store_data | output | 16 | Rounded store word |
| ovf_a | output | 1 | Sticky 32-bit range overflow, A |
| ovf_b | output | 1 | Sticky 32-bit range overflow, B |
| sat_a | output | 1 | Sticky clamp applied, A |
| sat_b | output | 1 | Sticky clamp applied, B |

## Verification
A wrong accumulator value shows on acc_a or acc_b one edge after the operation. It reaches store_data in the same cycle, because the rounding path is combinational. A corrupted guard bit stays hidden until a clamp or a store saturation decision depends on it. For that reason the long accumulation run checks the value one step before the 40-bit limit and again at the limit. A flag that fails to stick only shows after a later in-range write, so the bench performs such a write before sampling the flag.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_CLR   = 4'd1,
        OP_MPY   = 4'd2,
        OP_MPYN  = 4'd3,
        OP_MAC   = 4'd4,
        OP_MSC   = 4'd5,
        OP_SQR   = 4'd6,
        OP_SQRAC = 4'd7,
        OP_ED    = 4'd8,
        OP_EDAC  = 4'd9,
        OP_ADD   = 4'd10,
        OP_SUB   = 4'd11,
        OP_NEG   = 4'd12
    } dmac_op_e;

    typedef enum logic [1:0] {
        SRC_XY   = 2'd0,
        SRC_XX   = 2'd1,
        SRC_DIFF = 2'd2
    } mul_src_e;

    typedef enum logic [1:0] {
        ADD_ZERO = 2'd0,
        ADD_SELF = 2'd1
    } base_e;
endpackage

// File: rtl/dmac_mul.sv
module dmac_mul
    import dmac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  mul_src_e      src,
    input  logic          uns,
    input  logic          frac,
    output logic [AW-1:0] prod
);
    localparam int MW = DW + 1;
    localparam int PW = 2 * MW;

    logic signed [MW-1:0] xe, ye, ma, mb;
    logic signed [PW-1:0] p;
    logic        [PW:0]   ps;

    always_comb begin
        xe = uns ? {1'b0, x} : {x[DW-1], x};
        ye = uns ? {1'b0, y} : {y[DW-1], y};
        unique case (src)
            SRC_XX: begin
                ma = xe;
                mb = xe;
            end
            SRC_DIFF: begin
                // difference is always taken on signed operands
                ma = {x[DW-1], x} - {y[DW-1], y};
                mb = ma;
            end
            default: begin
                ma = xe;
                mb = ye;
            end
        endcase
        p    = ma * mb;
        ps   = frac ? {p, 1'b0} : {p[PW-1], p};
        prod = {{(AW-PW-1){ps[PW]}}, ps};
    end
endmodule

// File: rtl/dmac_addsat.sv
module dmac_addsat #(
    parameter int AW    = 40,
    parameter int GUARD = 8
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic          sub,
    input  logic          sat_en,
    input  logic          sat_mode,
    output logic [AW-1:0] res,
    output logic          ovf,
    output logic          sat_hit
);
    localparam int NW = AW - GUARD;
    localparam logic [AW-1:0] POS_N = {{(GUARD+1){1'b0}}, {(NW-1){1'b1}}};
    localparam logic [AW-1:0] NEG_N = {{(GUARD+1){1'b1}}, {(NW-1){1'b0}}};
    localparam logic [AW-1:0] POS_W = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] NEG_W = {1'b1, {(AW-1){1'b0}}};

    logic [AW:0] ea, eb, sum;
    logic        out_w, hit;

    always_comb begin
        ea      = {a[AW-1], a};
        eb      = {b[AW-1], b};
        sum     = sub ? (ea - eb) : (ea + eb);
        ovf     = !((&sum[AW:NW-1]) || !(|sum[AW:NW-1]));
        out_w   = sum[AW] ^ sum[AW-1];
        hit     = sat_mode ? out_w : ovf;
        sat_hit = sat_en && hit;
        if (!sat_hit)
            res = sum[AW-1:0];
        else if (sat_mode)
            res = sum[AW] ? NEG_W : POS_W;
        else
            res = sum[AW] ? NEG_N : POS_N;
    end
endmodule

// File: rtl/dmac_store.sv
module dmac_store #(
    parameter int DW    = 16,
    parameter int AW    = 40,
    parameter int GUARD = 8
) (
    input  logic [AW-1:0] acc,
    input  logic          conv,
    input  logic          sat_en,
    output logic [DW-1:0] word
);
    localparam int NW  = AW - GUARD;
    localparam int LSB = NW - DW;
    localparam logic [AW-1:0]  HALF = AW'(1) << (LSB - 1);
    localparam logic [LSB-1:0] TIE  = {1'b1, {(LSB-1){1'b0}}};

    logic [AW-1:0] rnd;
    logic          hold, over;

    always_comb begin
        hold = conv && (acc[LSB-1:0] == TIE) && !acc[LSB];
        rnd  = hold ? acc : (acc + HALF);
        over = !((&rnd[AW-1:NW-1]) || !(|rnd[AW-1:NW-1]));
        if (sat_en && over)
            word = rnd[AW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        else
            word = rnd[NW-1 -: DW];
    end
endmodule

// File: rtl/dmac_accreg.sv
module dmac_accreg #(
    parameter int AW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] din,
    input  logic          ovf_in,
    input  logic          sat_in,
    input  logic          clr,
    output logic [AW-1:0] acc,
    output logic          ovf,
    output logic          sat
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            ovf <= 1'b0;
            sat <= 1'b0;
        end else begin
            if (wr)
                acc <= din;
            if (clr) begin
                ovf <= 1'b0;
                sat <= 1'b0;
            end else begin
                if (wr && ovf_in) ovf <= 1'b1;
                if (wr && sat_in) sat <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 40,
    parameter int GUARD = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic          acc_sel,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic          frac_mode,
    input  logic          opnd_unsigned,
    input  logic          rnd_conv,
    input  logic          sat_en_a,
    input  logic          sat_en_b,
    input  logic          sat_mode,
    input  logic          store_sat_en,
    input  logic          store_sel,
    input  logic          flag_clr,
    output logic [AW-1:0] acc_a,
    output logic [AW-1:0] acc_b,
    output logic [DW-1:0] store_data,
    output logic          ovf_a,
    output logic          ovf_b,
    output logic          sat_a,
    output logic          sat_b
);
    localparam int NACC = 2;

    logic [NACC-1:0][AW-1:0] acc_w;
    logic [NACC-1:0]         ovf_w, sat_w, wr_w;
    logic [AW-1:0]           prod, cur, oth, opa, opb, res;
    logic                    sub, wr, ovf, sat_hit, sat_en;
    mul_src_e                src;

    dmac_mul #(.DW(DW), .AW(AW)) i_mul (
        .x(x_in), .y(y_in), .src(src), .uns(opnd_unsigned),
        .frac(frac_mode), .prod(prod)
    );

    // operand routing per opcode
    always_comb begin
        cur = acc_w[acc_sel];
        oth = acc_w[~acc_sel];
        src = SRC_XY;
        opa = '0;
        opb = '0;
        sub = 1'b0;
        wr  = op_valid;
        unique case (op_code)
            OP_CLR:   ;
            OP_MPY:   opb = prod;
            OP_MPYN:  begin opb = prod; sub = 1'b1; end
            OP_MAC:   begin opa = cur; opb = prod; end
            OP_MSC:   begin opa = cur; opb = prod; sub = 1'b1; end
            OP_SQR:   begin src = SRC_XX; opb = prod; end
            OP_SQRAC: begin src = SRC_XX; opa = cur; opb = prod; end
            OP_ED:    begin src = SRC_DIFF; opb = prod; end
            OP_EDAC:  begin src = SRC_DIFF; opa = cur; opb = prod; end
            OP_ADD:   begin opa = cur; opb = oth; end
            OP_SUB:   begin opa = cur; opb = oth; sub = 1'b1; end
            OP_NEG:   begin opb = cur; sub = 1'b1; end
            default:  wr = 1'b0;
        endcase
        sat_en = acc_sel ? sat_en_b : sat_en_a;
    end

    dmac_addsat #(.AW(AW), .GUARD(GUARD)) i_addsat (
        .a(opa), .b(opb), .sub(sub), .sat_en(sat_en), .sat_mode(sat_mode),
        .res(res), .ovf(ovf), .sat_hit(sat_hit)
    );

    for (genvar g = 0; g < NACC; g++) begin : g_acc
        assign wr_w[g] = wr && (acc_sel == g[0]);
        dmac_accreg #(.AW(AW)) i_reg (
            .clk(clk), .rst_n(rst_n), .wr(wr_w[g]), .din(res),
            .ovf_in(ovf), .sat_in(sat_hit), .clr(flag_clr),
            .acc(acc_w[g]), .ovf(ovf_w[g]), .sat(sat_w[g])
        );
    end

    dmac_store #(.DW(DW), .AW(AW), .GUARD(GUARD)) i_store (
        .acc(acc_w[store_sel]), .conv(rnd_conv), .sat_en(store_sat_en),
        .word(store_data)
    );

    assign acc_a = acc_w[0];
    assign acc_b = acc_w[1];
    assign ovf_a = ovf_w[0];
    assign ovf_b = ovf_w[1];
    assign sat_a = sat_w[0];
    assign sat_b = sat_w[1];
endmodule

// File: rtl/dmac_engine_chk.sv
module dmac_engine_chk #(
    parameter int DW    = 16,
    parameter int AW    = 40,
    parameter int GUARD = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [3:0]    op_code,
    input logic          acc_sel,
    input logic          sat_en_a,
    input logic          sat_mode,
    input logic          flag_clr,
    input logic [AW-1:0] acc_a,
    input logic [AW-1:0] acc_b,
    input logic          ovf_a,
    input logic          ovf_b,
    input logic          sat_a,
    input logic          sat_b
);
    localparam int NW = AW - GUARD;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_a) && $stable(acc_b)));

    p_other_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel) |=> $stable(acc_b));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd1 && !acc_sel) |=> (acc_a == '0));

    p_narrow_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel && sat_en_a && !sat_mode && op_code != 4'd0 && op_code < 4'd13)
        |=> ((&acc_a[AW-1:NW-1]) || !(|acc_a[AW-1:NW-1])));

    p_sticky_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_a && !flag_clr) |=> ovf_a);

    p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !(ovf_a || ovf_b || sat_a || sat_b));
endmodule

bind dmac_engine dmac_engine_chk #(.DW(DW), .AW(AW), .GUARD(GUARD)) i_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_sel(acc_sel), .sat_en_a(sat_en_a), .sat_mode(sat_mode),
    .flag_clr(flag_clr), .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a),
    .ovf_b(ovf_b), .sat_a(sat_a), .sat_b(sat_b)
);

// File: tb/test_dmac_engine.sv
module test_dmac_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        acc_sel = 1'b0;
    logic [15:0] x_in = '0, y_in = '0;
    logic        frac_mode = 1'b0, opnd_unsigned = 1'b0, rnd_conv = 1'b0;
    logic        sat_en_a = 1'b0, sat_en_b = 1'b0, sat_mode = 1'b0;
    logic        store_sat_en = 1'b0, store_sel = 1'b0, flag_clr = 1'b0;
    logic [39:0] acc_a, acc_b;
    logic [15:0] store_data;
    logic        ovf_a, ovf_b, sat_a, sat_b;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dmac_engine i_dmac_engine (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_sel(acc_sel), .x_in(x_in), .y_in(y_in), .frac_mode(frac_mode),
        .opnd_unsigned(opnd_unsigned), .rnd_conv(rnd_conv),
        .sat_en_a(sat_en_a), .sat_en_b(sat_en_b), .sat_mode(sat_mode),
        .store_sat_en(store_sat_en), .store_sel(store_sel), .flag_clr(flag_clr),
        .acc_a(acc_a), .acc_b(acc_b), .store_data(store_data),
        .ovf_a(ovf_a), .ovf_b(ovf_b), .sat_a(sat_a), .sat_b(sat_b)
    );

    task automatic chk40(input string req, input logic [39:0] got, input logic [39:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk16(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk1(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic do_op(input logic [3:0] op, input logic sel,
                         input logic [15:0] x, input logic [15:0] y);
        op_code  = op;
        acc_sel  = sel;
        x_in     = x;
        y_in     = y;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic clear_flags();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk40("R1 acc_a", acc_a, 40'h0);
        chk40("R1 acc_b", acc_b, 40'h0);
        chk1("R1 ovf_a", ovf_a, 1'b0);
        chk1("R1 sat_b", sat_b, 1'b0);
        chk16("R1 store", store_data, 16'h0000);
    endtask

    task automatic t_integer_mul();
        frac_mode = 0; opnd_unsigned = 0;
        do_op(4'd2, 0, 16'd3, 16'hFFFB);
        chk40("R4 MPY", acc_a, 40'hFFFFFFFFF1);
        do_op(4'd4, 0, 16'd2, 16'd4);
        chk40("R4 MAC", acc_a, 40'hFFFFFFFFF9);
        do_op(4'd5, 0, 16'd1, 16'd1);
        chk40("R4 MSC", acc_a, 40'hFFFFFFFFF8);
        do_op(4'd3, 1, 16'd6, 16'd7);
        chk40("R4 MPYN", acc_b, 40'hFFFFFFFFD6);
        chk40("R2 other acc untouched", acc_a, 40'hFFFFFFFFF8);
        op_code = 4'd1; acc_sel = 0;
        @(negedge clk);
        chk40("R2 no op_valid hold", acc_a, 40'hFFFFFFFFF8);
        do_op(4'd14, 0, 16'd1, 16'd1);
        chk40("R2 unused code", acc_a, 40'hFFFFFFFFF8);
        do_op(4'd1, 0, 16'd0, 16'd0);
        chk40("R3 CLR", acc_a, 40'h0);
        chk40("R3 CLR leaves B", acc_b, 40'hFFFFFFFFD6);
    endtask

    task automatic t_frac_uns();
        frac_mode = 1; opnd_unsigned = 0; rnd_conv = 0; store_sel = 0;
        do_op(4'd2, 0, 16'h4000, 16'h4000);
        chk40("R5 frac MPY", acc_a, 40'h0020000000);
        chk16("R12 store", store_data, 16'h2000);
        frac_mode = 0; opnd_unsigned = 1;
        do_op(4'd2, 0, 16'hFFFF, 16'h0002);
        chk40("R6 unsigned MPY", acc_a, 40'h000001FFFE);
    endtask

    task automatic t_square_ed();
        frac_mode = 0; opnd_unsigned = 0;
        do_op(4'd6, 0, 16'hFFFD, 16'd100);
        chk40("R7 SQR", acc_a, 40'd9);
        do_op(4'd7, 0, 16'd4, 16'd100);
        chk40("R7 SQRAC", acc_a, 40'd25);
        opnd_unsigned = 1;
        do_op(4'd8, 0, 16'd10, 16'd3);
        chk40("R7 ED", acc_a, 40'd49);
        do_op(4'd9, 0, 16'hFFFE, 16'd2);
        chk40("R7 EDAC signed diff", acc_a, 40'd65);
        opnd_unsigned = 0;
    endtask

    task automatic t_acc_ops();
        frac_mode = 0; opnd_unsigned = 0;
        do_op(4'd2, 0, 16'd10, 16'd10);
        do_op(4'd2, 1, 16'd5, 16'hFFFA);
        do_op(4'd10, 0, 16'd0, 16'd0);
        chk40("R8 ADD", acc_a, 40'd70);
        do_op(4'd11, 1, 16'd0, 16'd0);
        chk40("R8 SUB", acc_b, 40'hFFFFFFFF9C);
        do_op(4'd12, 0, 16'd0, 16'd0);
        chk40("R8 NEG", acc_a, 40'hFFFFFFFFBA);
        chk40("R8 NEG leaves B", acc_b, 40'hFFFFFFFF9C);
    endtask

    task automatic t_narrow_sat();
        clear_flags();
        frac_mode = 1; opnd_unsigned = 0; sat_en_a = 1; sat_mode = 0;
        do_op(4'd2, 0, 16'h8000, 16'h8000);
        chk40("R9 positive clamp", acc_a, 40'h007FFFFFFF);
        chk1("R11 ovf_a set", ovf_a, 1'b1);
        chk1("R11 sat_a set", sat_a, 1'b1);
        chk1("R11 sat_b untouched", sat_b, 1'b0);
        store_sel = 0; store_sat_en = 1; rnd_conv = 0;
        #1;
        chk16("R14 store clamp positive", store_data, 16'h7FFF);
        store_sat_en = 0;
        #1;
        chk16("R12 store unclamped", store_data, 16'h8000);
        do_op(4'd3, 0, 16'h8000, 16'h8000);
        do_op(4'd5, 0, 16'h8000, 16'h8000);
        chk40("R9 negative clamp", acc_a, 40'hFF80000000);
        do_op(4'd2, 0, 16'h0001, 16'h0001);
        chk1("R11 ovf_a sticky", ovf_a, 1'b1);
        chk1("R11 sat_a sticky", sat_a, 1'b1);
        clear_flags();
        chk1("R11 flag_clr ovf", ovf_a, 1'b0);
        chk1("R11 flag_clr sat", sat_a, 1'b0);
        sat_en_a = 0;
    endtask

    task automatic t_wide_sat();
        frac_mode = 1; opnd_unsigned = 0; sat_en_b = 1; sat_mode = 1;
        do_op(4'd2, 1, 16'h8000, 16'h8000);
        for (int i = 0; i < 254; i++) do_op(4'd4, 1, 16'h8000, 16'h8000);
        chk40("R10 below wide limit", acc_b, 40'h7F80000000);
        chk1("R10 no clamp yet", sat_b, 1'b0);
        chk1("R11 ovf_b beyond 32 bits", ovf_b, 1'b1);
        do_op(4'd4, 1, 16'h8000, 16'h8000);
        chk40("R10 wide clamp", acc_b, 40'h7FFFFFFFFF);
        chk1("R10 sat_b set", sat_b, 1'b1);
        sat_en_b = 0;
        do_op(4'd2, 1, 16'h8000, 16'h8000);
        for (int i = 0; i < 255; i++) do_op(4'd4, 1, 16'h8000, 16'h8000);
        chk40("R10 wrap when disabled", acc_b, 40'h8000000000);
        sat_mode = 0;
        clear_flags();
    endtask

    task automatic t_rounding();
        frac_mode = 0; opnd_unsigned = 1; store_sat_en = 0; store_sel = 0;
        do_op(4'd2, 0, 16'd3, 16'h8000);
        rnd_conv = 0; #1;
        chk16("R12 tie odd conventional", store_data, 16'h0002);
        rnd_conv = 1; #1;
        chk16("R13 tie odd convergent", store_data, 16'h0002);
        do_op(4'd2, 0, 16'd1, 16'h8000);
        rnd_conv = 0; #1;
        chk16("R12 tie even conventional", store_data, 16'h0001);
        rnd_conv = 1; #1;
        chk16("R13 tie even convergent", store_data, 16'h0000);
        do_op(4'd2, 0, 16'd1, 16'h8001);
        chk16("R13 above tie", store_data, 16'h0001);
        rnd_conv = 0;
    endtask

    task automatic t_store_neg();
        frac_mode = 1; opnd_unsigned = 1;
        do_op(4'd2, 1, 16'hFFFF, 16'hFFFF);
        chk40("R6 frac unsigned", acc_b, 40'h01FFFC0002);
        do_op(4'd12, 1, 16'd0, 16'd0);
        chk40("R8 NEG large", acc_b, 40'hFE0003FFFE);
        store_sel = 1; store_sat_en = 1; #1;
        chk16("R14 store clamp negative", store_data, 16'h8000);
        store_sat_en = 0; #1;
        chk16("R12 store from B", store_data, 16'h0004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_integer_mul();
        t_frac_uns();
        t_square_ed();
        t_acc_ops();
        t_narrow_sat();
        t_wide_sat();
        t_rounding();
        t_store_neg();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule